// File: doc/BRIEF.md
# Rectangle Copy and Fill Engine

This block moves rectangles of bytes inside a linear frame buffer. A host programs a source point, a destination point, the rectangle size, the two row pitches and a fill colour through simple register writes, then writes a control word with the start bit set. The engine then either copies the source rectangle onto the destination rectangle or paints the destination rectangle with the low byte of the colour. It raises a busy flag for the whole operation and drops it after the last byte is written.

Horizontal positions and widths are counted in bytes. Software scales pixel counts by the bytes per pixel before it writes them. The frame buffer starts at address 0, and a byte lives at row × pitch + column. When source and destination overlap, software chooses the stepping direction so that no source byte is overwritten before it has been read. In backward mode the points it writes are the bottom-right corners, and the engine walks leftwards and upwards.

The engine drives a single byte-wide memory port. A transfer completes in any cycle where a request and the memory's ready are both high, and read data is taken in that same cycle. A copy costs one read and one write per byte. A fill costs one write per byte.

Top module: `blit2d_engine`

## Requirements
- R1: Six registers are selected by byte offset on `reg_addr`, and each reads back what was last written to it. They are: 0x00 source point, 0x04 destination point, 0x08 size, 0x0C control, 0x10 pitches and 0x14 colour. Points pack the column in bits 31:16 and the row in bits 15:0. The size packs the width in bytes in bits 31:16 and the height in bits 15:0. The pitch register holds the destination pitch in bits 31:16 and the source pitch in bits 15:0. All registers are zero after reset.
- R2: A control write with bit 31 set, a command (bits 19:16) of 0 or 1, and a nonzero width and height starts an operation while the engine is idle. `busy` is high from the next cycle on. Bit 31 of the control register reads as `busy` and returns to 0 by itself when the last byte has been written.
- R3: A forward copy (command 0, control bit 27 clear) steps along each row with the column increasing, then moves to the next row down. For each byte it reads source address sy×spitch+sx and then writes that byte to destination address dy×dpitch+dx.
- R4: With control bit 27 set, the source and destination points are the bottom-right corners. The copy steps with the column decreasing within each row and then moves to the row above, so both x and y decrement.
- R5: When source and destination overlap and software applies the direction rule, the destination holds an exact image of the original source. The rule is: backward when the source row is above the destination row, or when the rows are equal and the source column is to the left.
- R6: A fill (command 1) writes the low byte of the colour register to every destination byte, one write per accepted transfer, and never issues a read.
- R7: While a request is not accepted (`mem_ready` low), the address, direction and data of that request stay unchanged and the operation does not advance.
- R8: While `busy` is high, all register writes are ignored, including a new start.
- R9: A start with a width or height of zero completes at once. `busy` stays low and no memory access is made.
- R10: A start with a command code other than 0 or 1 launches nothing.
- R11: While idle the engine issues no memory requests, and `busy` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write (1) or a read (0) |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with `mem_ready` |
| mem_ready | input | 1 | Memory accepts the request this cycle |

## Verification
On every cycle the assertions check several properties. No request is made while idle. A stalled request stays frozen. Every accepted copy read is followed by a write. A fill never reads. Writes during an operation leave the registers alone. A legal start raises busy, and a zero-sized start does not. The scenarios alone can show whether the bytes land at the right addresses in the right order. Only they can show that overlapping copies in either direction reproduce the original source, and that a fill and the copies under random memory stalls leave the whole frame buffer equal to the bench's reference image.

// File: rtl/blit2d_engine.sv
module blit2d_engine #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata,
  input  logic          mem_ready
);
  localparam logic [4:0] A_SRC = 5'h00;
  localparam logic [4:0] A_DST = 5'h04;
  localparam logic [4:0] A_DIM = 5'h08;
  localparam logic [4:0] A_CTL = 5'h0C;
  localparam logic [4:0] A_PIT = 5'h10;
  localparam logic [4:0] A_COL = 5'h14;

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR} state_t;

  state_t      state;
  logic [31:0] src_pt, dst_pt, dims, ctrl, pitch, fg;
  logic [15:0] col, row;
  logic [7:0]  dbuf;
  logic [15:0] sx, sy, dx, dy;
  logic [31:0] src_lin, dst_lin;

  wire [15:0] wid     = dims[31:16];
  wire [15:0] hgt     = dims[15:0];
  wire        back    = ctrl[27];
  wire        is_fill = (ctrl[19:16] == 4'd1);
  wire        xfer    = mem_req && mem_ready;
  wire        last    = (col == wid - 16'd1) && (row == hgt - 16'd1);
  wire        start_ok = reg_we && (reg_addr == A_CTL) && reg_wdata[31] &&
                         (state == ST_IDLE) && (reg_wdata[19:16] <= 4'd1) &&
                         (wid != 16'd0) && (hgt != 16'd0);

  assign sx = back ? src_pt[31:16] - col : src_pt[31:16] + col;
  assign sy = back ? src_pt[15:0]  - row : src_pt[15:0]  + row;
  assign dx = back ? dst_pt[31:16] - col : dst_pt[31:16] + col;
  assign dy = back ? dst_pt[15:0]  - row : dst_pt[15:0]  + row;

  assign src_lin = 32'(sy) * 32'(pitch[15:0])  + 32'(sx);
  assign dst_lin = 32'(dy) * 32'(pitch[31:16]) + 32'(dx);

  assign busy      = (state != ST_IDLE);
  assign mem_req   = busy;
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = (state == ST_RD) ? src_lin[AW-1:0] : dst_lin[AW-1:0];
  assign mem_wdata = is_fill ? fg[7:0] : dbuf;

  always_comb begin
    case (reg_addr)
      A_SRC:   reg_rdata = src_pt;
      A_DST:   reg_rdata = dst_pt;
      A_DIM:   reg_rdata = dims;
      A_CTL:   reg_rdata = {busy, ctrl[30:0]};
      A_PIT:   reg_rdata = pitch;
      A_COL:   reg_rdata = fg;
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_pt <= '0;
      dst_pt <= '0;
      dims   <= '0;
      ctrl   <= '0;
      pitch  <= '0;
      fg     <= '0;
    end else if (reg_we && state == ST_IDLE) begin
      case (reg_addr)
        A_SRC: src_pt <= reg_wdata;
        A_DST: dst_pt <= reg_wdata;
        A_DIM: dims   <= reg_wdata;
        A_CTL: ctrl   <= {1'b0, reg_wdata[30:0]};
        A_PIT: pitch  <= reg_wdata;
        A_COL: fg     <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      col   <= '0;
      row   <= '0;
      dbuf  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_ok) begin
          col   <= '0;
          row   <= '0;
          state <= (reg_wdata[19:16] == 4'd1) ? ST_WR : ST_RD;
        end
        ST_RD: if (xfer) begin
          dbuf  <= mem_rdata;
          state <= ST_WR;
        end
        ST_WR: if (xfer) begin
          if (last) begin
            state <= ST_IDLE;
          end else begin
            if (col == wid - 16'd1) begin
              col <= '0;
              row <= row + 16'd1;
            end else begin
              col <= col + 16'd1;
            end
            state <= is_fill ? ST_WR : ST_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/blit2d_engine_chk.sv
module blit2d_engine_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [4:0]    reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_wdata,
  input logic          mem_ready,
  input logic [31:0]   dims,
  input logic [31:0]   fg,
  input logic [31:0]   ctrl
);
  wire ctl_start = reg_we && reg_addr == 5'h0C && reg_wdata[31] && !busy;
  wire dims_zero = (dims[31:16] == 16'd0) || (dims[15:0] == 16'd0);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ready && !mem_we |=> mem_req && mem_we);

  p_fill_no_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && ctrl[19:16] == 4'd1 |-> mem_we);

  p_frozen_regs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_we |=> $stable(dims) && $stable(fg) && $stable(ctrl));

  p_zero_dim_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_start && dims_zero |=> !busy);

  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_start && !dims_zero && reg_wdata[19:16] <= 4'd1 |=> busy);

  p_bad_cmd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_start && reg_wdata[19:16] > 4'd1 |=> !busy);
endmodule

bind blit2d_engine blit2d_engine_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .busy(busy), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .dims(dims), .fg(fg), .ctrl(ctrl)
);

// File: tb/sim_blit2d_engine.sv
module sim_blit2d_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int FB = 4096;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          reg_we = 0;
  logic [4:0]    reg_addr = 0;
  logic [31:0]   reg_wdata = 0;
  logic [31:0]   reg_rdata;
  logic          busy, mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata, mem_rdata;
  logic          mem_ready = 0;
  logic          hold_low = 0;

  logic [7:0] fb     [0:FB-1];
  logic [7:0] ref_fb [0:FB-1];
  logic [7:0] snap   [0:FB-1];

  int checks = 0, errors = 0, cyc = 0;
  int n_rd = 0, n_wr = 0, n_idle_req = 0;

  blit2d_engine #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  assign mem_rdata = fb[mem_addr[11:0]];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        fb[mem_addr[11:0]] <= mem_wdata;
        n_wr <= n_wr + 1;
      end else begin
        n_rd <= n_rd + 1;
      end
    end
    if (!busy && mem_req) n_idle_req <= n_idle_req + 1;
  end

  always @(negedge clk) mem_ready <= hold_low ? 1'b0 : ($urandom_range(3) != 0);

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] cw(input bit back, input int cmd);
    return 32'h8000_800C | (32'(back) << 27) | (32'(cmd) << 16);
  endfunction

  task automatic ref_op(input int sx0, input int sy0, input int dx0, input int dy0,
                        input int w, input int h, input bit back, input bit fill,
                        input logic [7:0] colr, input int sp, input int dp);
    for (int j = 0; j < h; j++)
      for (int i = 0; i < w; i++) begin
        int sx = back ? sx0 - i : sx0 + i;
        int sy = back ? sy0 - j : sy0 + j;
        int dx = back ? dx0 - i : dx0 + i;
        int dy = back ? dy0 - j : dy0 + j;
        ref_fb[dy*dp + dx] = fill ? colr : ref_fb[sy*sp + sx];
      end
  endtask

  task automatic cmp_fb(input string tag);
    int mism = 0;
    for (int k = 0; k < FB; k++) if (fb[k] !== ref_fb[k]) mism++;
    chk(tag, mism, 0);
  endtask

  task automatic setup(input int sx, input int sy, input int dx, input int dy,
                       input int w, input int h, input int sp, input int dp,
                       input logic [31:0] colr);
    wr(5'h00, {16'(sx), 16'(sy)});
    wr(5'h04, {16'(dx), 16'(dy)});
    wr(5'h08, {16'(w), 16'(h)});
    wr(5'h10, {16'(dp), 16'(sp)});
    wr(5'h14, colr);
  endtask

  task automatic do_op(input string tag, input int sx, input int sy, input int dx, input int dy,
                       input int w, input int h, input bit back, input bit fill,
                       input logic [31:0] colr, input int sp, input int dp);
    int r0, w0;
    setup(sx, sy, dx, dy, w, h, sp, dp, colr);
    r0 = n_rd; w0 = n_wr;
    wr(5'h0C, cw(back, fill ? 1 : 0));
    wait_idle();
    ref_op(sx, sy, dx, dy, w, h, back, fill, colr[7:0], sp, dp);
    cmp_fb({tag, " image"});
    chk({tag, " writes"}, n_wr - w0, w*h);
    chk({tag, " reads"}, n_rd - r0, fill ? 0 : w*h);
  endtask

  initial begin
    logic [31:0] v;
    int a0, r0, w0;
    void'($urandom(32'd20240917));
    for (int k = 0; k < FB; k++) begin
      fb[k] = 8'($urandom);
      ref_fb[k] = fb[k];
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    chk("R11 busy after reset", busy, 0);
    for (int k = 0; k < 6; k++) begin
      rd(5'(k*4), v);
      chk("R1 reset value", v, 0);
    end
    repeat (5) @(negedge clk);
    chk("R11 no idle request", n_idle_req, 0);

    wr(5'h00, 32'h0012_0034); wr(5'h04, 32'h0056_0078);
    wr(5'h08, 32'h0009_000A); wr(5'h0C, 32'h0801_800C);
    wr(5'h10, 32'h0030_0040); wr(5'h14, 32'hDEAD_BEEF);
    rd(5'h00, v); chk("R1 src", v, 32'h0012_0034);
    rd(5'h04, v); chk("R1 dst", v, 32'h0056_0078);
    rd(5'h08, v); chk("R1 dims", v, 32'h0009_000A);
    rd(5'h0C, v); chk("R1 ctrl", v, 32'h0801_800C);
    rd(5'h10, v); chk("R1 pitch", v, 32'h0030_0040);
    rd(5'h14, v); chk("R1 colour", v, 32'hDEAD_BEEF);
    chk("R2 no start without bit31", busy, 0);

    setup(2, 3, 0, 0, 3, 2, 64, 64, 32'h0000_0011);
    @(negedge clk); reg_we = 1; reg_addr = 5'h0C; reg_wdata = cw(0, 1);
    @(negedge clk); reg_we = 0;
    chk("R2 busy after start", busy, 1);
    rd(5'h0C, v); chk("R2 start bit reads busy", v[31], 1);
    wait_idle();
    rd(5'h0C, v); chk("R2 start bit cleared", v[31], 0);
    ref_op(2, 3, 0, 0, 3, 2, 0, 1, 8'h11, 64, 64);
    cmp_fb("R6 small fill");

    do_op("R3 forward copy", 3, 2, 20, 30, 7, 4, 0, 0, 0, 64, 48);
    do_op("R4 backward copy", 40, 12, 30, 40, 6, 5, 1, 0, 0, 64, 64);

    for (int k = 0; k < FB; k++) snap[k] = fb[k];
    do_op("R5 overlap backward", 10+7, 5+5, 12+7, 7+5, 8, 6, 1, 0, 0, 64, 64);
    begin
      int m = 0;
      for (int j = 0; j < 6; j++) for (int i = 0; i < 8; i++)
        if (fb[(7+j)*64 + 12+i] !== snap[(5+j)*64 + 10+i]) m++;
      chk("R5 overlap backward image", m, 0);
    end
    for (int k = 0; k < FB; k++) snap[k] = fb[k];
    do_op("R5 overlap forward", 12, 7, 10, 5, 8, 6, 0, 0, 0, 64, 64);
    begin
      int m = 0;
      for (int j = 0; j < 6; j++) for (int i = 0; i < 8; i++)
        if (fb[(5+j)*64 + 10+i] !== snap[(7+j)*64 + 12+i]) m++;
      chk("R5 overlap forward image", m, 0);
    end
    for (int k = 0; k < FB; k++) snap[k] = fb[k];
    do_op("R5 same row shift right", 20, 15, 23, 15+0, 9, 1, 0, 0, 0, 64, 64);
    for (int k = 0; k < FB; k++) begin fb[k] = snap[k]; ref_fb[k] = snap[k]; end
    do_op("R5 same row backward", 20+8, 15, 23+8, 15, 9, 1, 1, 0, 0, 64, 64);
    begin
      int m = 0;
      for (int i = 0; i < 9; i++) if (fb[15*64 + 23+i] !== snap[15*64 + 20+i]) m++;
      chk("R5 same row image", m, 0);
    end

    do_op("R6 fill", 0, 0, 5, 20, 10, 3, 0, 1, 32'h1234_56A5, 64, 40);

    setup(4, 6, 30, 2, 3, 2, 64, 64, 0);
    hold_low = 1;
    r0 = n_rd; w0 = n_wr;
    wr(5'h0C, cw(0, 0));
    a0 = int'(mem_addr);
    chk("R7 first address", a0, 6*64 + 4);
    repeat (5) @(negedge clk);
    chk("R7 address held", mem_addr, a0);
    chk("R7 no progress", (n_rd - r0) + (n_wr - w0), 0);
    hold_low = 0;
    wait_idle();
    ref_op(4, 6, 30, 2, 3, 2, 0, 0, 0, 64, 64);
    cmp_fb("R7 copy after stall");

    setup(0, 0, 40, 30, 4, 4, 64, 64, 32'h0000_00AA);
    wr(5'h0C, cw(0, 1));
    wr(5'h14, 32'h0000_0055);
    wr(5'h0C, cw(0, 0));
    wr(5'h08, 32'h0001_0001);
    wait_idle();
    rd(5'h14, v); chk("R8 colour unchanged", v, 32'h0000_00AA);
    rd(5'h08, v); chk("R8 dims unchanged", v, 32'h0004_0004);
    ref_op(0, 0, 40, 30, 4, 4, 0, 1, 8'hAA, 64, 64);
    cmp_fb("R8 fill result");
    @(negedge clk); chk("R8 no restart", busy, 0);

    r0 = n_rd; w0 = n_wr;
    wr(5'h08, 32'h0000_0005);
    wr(5'h0C, cw(0, 1));
    chk("R9 zero width busy", busy, 0);
    wr(5'h08, 32'h0005_0000);
    wr(5'h0C, cw(0, 0));
    chk("R9 zero height busy", busy, 0);
    repeat (3) @(negedge clk);
    chk("R9 no access", (n_rd - r0) + (n_wr - w0), 0);

    wr(5'h08, 32'h0003_0003);
    wr(5'h0C, cw(0, 2));
    chk("R10 bad command busy", busy, 0);
    repeat (3) @(negedge clk);
    chk("R10 no access", (n_rd - r0) + (n_wr - w0), 0);
    cmp_fb("R10 image intact");

    for (int t = 0; t < 40; t++) begin
      int sx = $urandom_range(40), sy = $urandom_range(35);
      int dx = $urandom_range(40), dy = $urandom_range(35);
      int w = $urandom_range(1, 12), h = $urandom_range(1, 8);
      bit fill = ($urandom_range(3) == 0);
      bit back = (sy < dy) || (sy == dy && sx < dx);
      if (fill) back = 0;
      if (back) do_op("R4 random", sx+w-1, sy+h-1, dx+w-1, dy+h-1, w, h, 1, 0, 0, 64, 64);
      else do_op(fill ? "R6 random" : "R3 random", sx, sy, dx, dy, w, h, 0, fill,
                 32'($urandom), 64, 64);
    end
    chk("R11 no idle request at end", n_idle_req, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule